// File: doc/BRIEF.md
# Pulse-Length Serial Byte Transmitter

This block sends bytes over one output wire for a slow sampler, such as an audio input, to capture. Each bit becomes a high pulse whose length gives its value. A short low gap follows each bit, and a longer low gap follows the eighth bit to mark the end of a byte. There are no start bits, stop bits or parity.

Bytes enter through a valid/ready handshake. All timing comes from four clock-cycle parameters: short pulse, long pulse, bit gap and byte gap. The line stays low while nothing is queued. A byte offered while the byte gap is still running waits at the input until that gap has fully elapsed. It then goes out with no extra idle cycle.

Top module: `pulse_len_tx`

## Requirements
- R1: A bit of value 0 drives `line_o` high for exactly `SHORT_CYC` consecutive cycles.
- R2: A bit of value 1 drives `line_o` high for exactly `LONG_CYC` consecutive cycles, and `LONG_CYC` must be at least twice `SHORT_CYC`.
- R3: Between two consecutive bits of the same byte, `line_o` is low for exactly `BIT_GAP_CYC` cycles.
- R4: After the last bit of a byte, `line_o` is low for exactly `BYTE_GAP_CYC` cycles before the next byte's first pulse when a byte is waiting.
- R5: Each byte is sent as 8 pulses, bit 0 (least significant) first and bit 7 last, with no leading marker pulse.
- R6: After reset, and whenever no byte is queued after a byte gap, `line_o` is low and `ready_o` is high.
- R7: `ready_o` is low from the acceptance of a byte until the last cycle of that byte's byte gap, and it is high in that last cycle.
- R8: A byte is taken at a rising clock edge where `valid_i` and `ready_o` are both high. `line_o` goes high in the very next cycle, and later changes on `data_i` do not alter the byte being sent.
- R9: A byte presented during the byte gap before its last cycle is not taken early. It is accepted in the last gap cycle, and the gap keeps its full `BYTE_GAP_CYC` length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | DATA_W | Byte to send |
| valid_i | input | 1 | `data_i` holds a byte to send |
| ready_o | output | 1 | Block can take a byte this cycle |
| line_o | output | 1 | Pulse-coded serial output |

## Verification
Two events can fall in the same cycle: the byte gap expiring, and the next byte being accepted. When they coincide, the next pulse must follow the gap with no idle cycle and no shortened gap. The bench provokes this by holding `valid_i` across a whole byte, and also by raising it early in the middle of a gap. It then measures the low run between the two bytes and checks that it equals `BYTE_GAP_CYC`. It also checks that `ready_o` first rises in the final gap cycle and that the second byte decodes correctly.

// File: rtl/pulse_len_tx_pkg.sv
package pulse_len_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SPACE = 2'd2,
    ST_FGAP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/pulse_len_timer.sv
module pulse_len_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // interval is only restarted once the previous one has run out (R3, R4)
  p_reload_expired_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> done_o);
endmodule

// File: rtl/pulse_len_shift.sv
module pulse_len_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= data_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= sr_q >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (idx_q == IDX_W'(DATA_W - 1));

  // never advance past the final bit of a byte (R5)
  p_no_shift_past_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o);
endmodule

// File: rtl/pulse_len_tx.sv
module pulse_len_tx
  import pulse_len_tx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SHORT_CYC    = 4,
  parameter int LONG_CYC     = 10,
  parameter int BIT_GAP_CYC  = 3,
  parameter int BYTE_GAP_CYC = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o
);
  localparam int MAX_A = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int MAX_B = (BIT_GAP_CYC > BYTE_GAP_CYC) ? BIT_GAP_CYC : BYTE_GAP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  initial begin
    p_long_twice_short_r2: assert (LONG_CYC >= 2 * SHORT_CYC && SHORT_CYC >= 1
                                   && BIT_GAP_CYC >= 1 && BYTE_GAP_CYC >= 1);
  end

  tx_state_e        state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_bit, sh_last;

  function automatic logic [CNT_W-1:0] mark_len(input logic b);
    return b ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
  endfunction

  pulse_len_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  pulse_len_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .data_i  (data_i),
    .shift_i (sh_shift),
    .bit_o   (sh_bit),
    .last_o  (sh_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (valid_i) begin
          sh_load  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = mark_len(data_i[0]);
          state_d  = ST_MARK;
        end
      end
      ST_MARK: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (sh_last) begin
            tmr_val = CNT_W'(BYTE_GAP_CYC - 1);
            state_d = ST_FGAP;
          end else begin
            tmr_val  = CNT_W'(BIT_GAP_CYC - 1);
            sh_shift = 1'b1;
            state_d  = ST_SPACE;
          end
        end
      end
      ST_SPACE: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = mark_len(sh_bit);
          state_d  = ST_MARK;
        end
      end
      ST_FGAP: begin
        // a queued byte starts only in the final gap cycle
        if (tmr_done) begin
          if (valid_i) begin
            sh_load  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = mark_len(data_i[0]);
            state_d  = ST_MARK;
          end else begin
            state_d  = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_FGAP && tmr_done);
  assign line_o  = (state_q == ST_MARK);

  // high-run length monitor for the pulse-width property
  logic [15:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_len_q <= '0;
    else if (!line_o)             hi_len_q <= '0;
    else if (hi_len_q != 16'hffff) hi_len_q <= hi_len_q + 1'b1;
  end

  p_pulse_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_o) |-> (hi_len_q == 16'(SHORT_CYC) || hi_len_q == 16'(LONG_CYC)));

  p_busy_not_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> !ready_o);

  p_accept_starts_mark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> line_o);
endmodule

// File: tb/pulse_len_tx_tb.sv
module pulse_len_tx_tb_top;
  localparam int DATA_W   = 8;
  localparam int SHORT    = 4;
  localparam int LONG     = 10;
  localparam int BIT_GAP  = 3;
  localparam int BYTE_GAP = 12;
  localparam int GAP_CAP  = BYTE_GAP + 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              valid_i = 1'b0;
  logic              ready_o, line_o;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  always #4 clk_i = ~clk_i;

  pulse_len_tx #(
    .DATA_W(DATA_W), .SHORT_CYC(SHORT), .LONG_CYC(LONG),
    .BIT_GAP_CYC(BIT_GAP), .BYTE_GAP_CYC(BYTE_GAP)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .valid_i(valid_i), .ready_o(ready_o), .line_o(line_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // receiver state filled by rx_byte
  logic [7:0] rx_b;
  int rx_hl[8];
  int rx_gap, rx_rdy_at, rx_busy, rx_badgap;

  task automatic rx_byte();
    int h, l, wd;
    rx_b = '0; rx_gap = 0; rx_rdy_at = 0; rx_busy = 0; rx_badgap = 0;
    wd = 0;
    while (!line_o && wd < 5000) begin @(negedge clk_i); wd++; end
    for (int i = 0; i < 8; i++) begin
      h = 0;
      while (line_o) begin
        if (ready_o) rx_busy++;
        h++;
        @(negedge clk_i);
      end
      rx_hl[i] = h;
      if (h == LONG) rx_b[i] = 1'b1;
      l = 0;
      while (!line_o && l < GAP_CAP) begin
        l++;
        if (ready_o) begin
          if (i < 7) rx_busy++;
          else if (rx_rdy_at == 0) rx_rdy_at = l;
        end
        @(negedge clk_i);
      end
      if (i < 7 && l != BIT_GAP) rx_badgap++;
      if (i == 7) rx_gap = l;
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk_i);
    data_i = d; valid_i = 1'b1;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    data_i = ~d;
    chk(line_o == 1'b1, "R8 line high cycle after accept", int'(line_o), 1);
  endtask

  task automatic check_byte(input logic [7:0] exp);
    chk(rx_b == exp, "R5 decoded byte", int'(rx_b), int'(exp));
    for (int i = 0; i < 8; i++) begin
      if (exp[i]) chk(rx_hl[i] == LONG, "R2 one pulse width", rx_hl[i], LONG);
      else        chk(rx_hl[i] == SHORT, "R1 zero pulse width", rx_hl[i], SHORT);
    end
    chk(rx_badgap == 0, "R3 bit gaps", rx_badgap, 0);
    chk(rx_busy == 0, "R7 ready low while busy", rx_busy, 0);
    chk(rx_rdy_at == BYTE_GAP, "R7 ready in last gap cycle", rx_rdy_at, BYTE_GAP);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(line_o == 1'b0, "R6 line low after reset", int'(line_o), 0);
    chk(ready_o == 1'b1, "R6 ready after reset", int'(ready_o), 1);
  endtask

  task automatic t_single(input logic [7:0] d);
    fork
      send(d);
      rx_byte();
    join
    check_byte(d);
    chk(rx_gap == GAP_CAP, "R6 line stays low when idle", rx_gap, GAP_CAP);
    chk(ready_o == 1'b1 && line_o == 1'b0, "R6 idle ready", int'(ready_o), 1);
  endtask

  task automatic t_back_to_back(input logic [7:0] a, input logic [7:0] b);
    int g1;
    fork
      begin send(a); send(b); end
      begin
        rx_byte(); check_byte(a); g1 = rx_gap;
        rx_byte(); check_byte(b);
      end
    join
    chk(g1 == BYTE_GAP, "R4 byte gap exact", g1, BYTE_GAP);
    chk(rx_gap == GAP_CAP, "R6 idle after second byte", rx_gap, GAP_CAP);
  endtask

  task automatic t_early_valid(input logic [7:0] a, input logic [7:0] b);
    int g1, falls, waited;
    bit prev;
    fork
      begin
        send(a);
        falls = 0; prev = 1'b1;
        while (falls < 8) begin
          @(negedge clk_i);
          if (prev && !line_o) falls++;
          prev = line_o;
        end
        @(negedge clk_i);
        data_i = b; valid_i = 1'b1;
        chk(ready_o == 1'b0, "R9 not ready mid gap", int'(ready_o), 0);
        waited = 0;
        while (!ready_o) begin @(negedge clk_i); waited++; end
        chk(waited == BYTE_GAP - 2, "R9 held until gap end", waited, BYTE_GAP - 2);
        @(negedge clk_i);
        valid_i = 1'b0; data_i = 8'h00;
        chk(line_o == 1'b1, "R9 mark right after gap", int'(line_o), 1);
      end
      begin
        rx_byte(); check_byte(a); g1 = rx_gap;
        rx_byte(); check_byte(b);
      end
    join
    chk(g1 == BYTE_GAP, "R9 gap not shortened", g1, BYTE_GAP);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single(8'hA5);
    t_single(8'h00);
    t_single(8'hFF);
    t_single(8'h01);
    t_single(8'h80);
    t_back_to_back(8'h3C, 8'hC3);
    t_early_valid(8'h5A, 8'h96);
    repeat (4) @(negedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule